// File: doc/BRIEF.md
# Single-Step Non-Restoring Division Unit

This block performs one step of a bit-serial, non-restoring binary division per clock. A controlling sequencer first issues a setup operation that seeds three status bits: a quotient-polarity bit Q, a divisor-sign bit M and a flag T. It then issues one step operation per quotient bit. Each step shifts the partial remainder left by one, with T entering at bit 0. It then either subtracts or adds the divisor. The choice depends only on the previous Q and M, never on a full comparison of the remainder. The step leaves the next quotient bit in T.

The unit has no sequencer of its own. The caller feeds back the remainder and status bits on each step and collects the T bits, typically by rotating them into the dividend register. Every operation writes its results into output registers, which are visible one clock edge later. Two setup flavours exist: a signed one that derives Q and M from operand signs, and an unsigned one that clears all three status bits.

Top module: `div_step_unit`

## Requirements
- R1: While rst_ni is low, rn_o, q_o, m_o and t_o are all 0.
- R2: Operation code 2'b10 (signed setup) sets q_o to bit 31 of rn_i, m_o to bit 31 of rm_i, t_o to q_o XOR m_o, and rn_o to rn_i unchanged.
- R3: Operation code 2'b01 (unsigned setup) clears q_o, m_o and t_o whatever q_i, m_i and t_i hold, and sets rn_o to rn_i unchanged.
- R4: Operation code 2'b11 (step) forms S = {rn_i[30:0], t_i}. When q_i equals m_i it sets rn_o to S minus rm_i (modulo 2^32); otherwise it sets rn_o to S plus rm_i (modulo 2^32).
- R5: On a step, q_o becomes rn_i[31] XOR c XOR m_i. Here c is the borrow out of the subtraction or the carry out of the addition in R4.
- R6: On a step, m_o keeps the value of m_i, and t_o is 1 exactly when the new q_o equals m_o.
- R7: Operation code 2'b00 (hold) leaves all four outputs unchanged, whatever the data and status inputs hold.
- R8: Each result appears on the outputs after the first rising clock edge following the cycle in which the operation is presented, so one operation completes per clock.
- R9: Run an unsigned setup with a zero remainder. Then run 32 rounds, each one rotating T into the dividend through its top bit and applying one step with the divisor. A final rotate then leaves the dividend register holding floor(dividend / divisor) for any nonzero divisor.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 2 | Operation: 00 hold, 01 unsigned setup, 10 signed setup, 11 step |
| rn_i | input | 32 | Partial remainder or dividend operand |
| rm_i | input | 32 | Divisor operand |
| q_i | input | 1 | Current Q bit |
| m_i | input | 1 | Current M bit |
| t_i | input | 1 | Current T bit |
| rn_o | output | 32 | Registered new remainder |
| q_o | output | 1 | Registered new Q bit |
| m_o | output | 1 | Registered new M bit |
| t_o | output | 1 | Registered new T bit (quotient bit after a step) |

## Verification
The hardest situations to reach are the wrap cases. These are an addition that carries out of bit 31 while the shifted-out bit is also set, and a subtraction that borrows when Q and M are both 1. Neither case shows up in ordinary small-operand divisions. The stimulus therefore drives every combination of the three input status bits directly against operands near the top of the range, such as all-ones and values with bit 31 set. Full 32-step unsigned divisions then feed the outputs back as inputs. They use operands such as all-ones by one, all-ones by all-ones and dividends smaller than the divisor. This drives the remainder through long runs of alternating add and subtract steps, and the assembled quotient is compared with integer division.

// File: rtl/div_step_pkg.sv
package div_step_pkg;

  typedef enum logic [1:0] {
    OP_HOLD = 2'b00,
    OP_CLR  = 2'b01,
    OP_SIGN = 2'b10,
    OP_STEP = 2'b11
  } div_op_e;

  typedef struct packed {
    logic q;
    logic m;
    logic t;
  } div_flags_t;

endpackage

// File: rtl/div_setup.sv
module div_setup
  import div_step_pkg::*;
(
  input  logic       signed_i,
  input  logic       rn_msb_i,
  input  logic       rm_msb_i,
  output div_flags_t flags_o
);

  always_comb begin
    if (signed_i) begin
      flags_o.q = rn_msb_i;
      flags_o.m = rm_msb_i;
      flags_o.t = rn_msb_i ^ rm_msb_i;
    end else begin
      flags_o = '0;
    end
  end

endmodule

// File: rtl/div_iter.sv
module div_iter
  import div_step_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] rn_i,
  input  logic [W-1:0] rm_i,
  input  div_flags_t   flags_i,
  output logic [W-1:0] rn_o,
  output div_flags_t   flags_o
);

  localparam int unsigned MSB = W - 1;

  logic [W-1:0] shifted;
  logic [W:0]   ext;
  logic         do_sub;
  logic         cy;
  logic         nq;

  assign shifted = {rn_i[MSB-1:0], flags_i.t};
  assign do_sub  = (flags_i.q == flags_i.m);

  // extra top bit of the widened result is borrow (sub) or carry (add)
  always_comb begin
    if (do_sub) ext = {1'b0, shifted} - {1'b0, rm_i};
    else        ext = {1'b0, shifted} + {1'b0, rm_i};
  end

  assign cy   = ext[W];
  assign nq   = rn_i[MSB] ^ cy ^ flags_i.m;
  assign rn_o = ext[MSB:0];

  assign flags_o.q = nq;
  assign flags_o.m = flags_i.m;
  assign flags_o.t = (nq == flags_i.m);

endmodule

// File: rtl/div_step_unit.sv
module div_step_unit
  import div_step_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [1:0]   op_i,
  input  logic [W-1:0] rn_i,
  input  logic [W-1:0] rm_i,
  input  logic         q_i,
  input  logic         m_i,
  input  logic         t_i,
  output logic [W-1:0] rn_o,
  output logic         q_o,
  output logic         m_o,
  output logic         t_o
);

  localparam int unsigned MSB = W - 1;

  div_op_e      op;
  div_flags_t   in_flags;
  div_flags_t   setup_flags;
  div_flags_t   step_flags;
  div_flags_t   flags_q;
  logic [W-1:0] step_rn;
  logic [W-1:0] rn_q;

  assign op       = div_op_e'(op_i);
  assign in_flags = '{q: q_i, m: m_i, t: t_i};

  div_setup i_setup (
    .signed_i (op == OP_SIGN),
    .rn_msb_i (rn_i[MSB]),
    .rm_msb_i (rm_i[MSB]),
    .flags_o  (setup_flags)
  );

  div_iter #(.W(W)) i_iter (
    .rn_i    (rn_i),
    .rm_i    (rm_i),
    .flags_i (in_flags),
    .rn_o    (step_rn),
    .flags_o (step_flags)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rn_q    <= '0;
      flags_q <= '0;
    end else begin
      unique case (op)
        OP_CLR, OP_SIGN: begin
          rn_q    <= rn_i;
          flags_q <= setup_flags;
        end
        OP_STEP: begin
          rn_q    <= step_rn;
          flags_q <= step_flags;
        end
        default: ;
      endcase
    end
  end

  assign rn_o = rn_q;
  assign q_o  = flags_q.q;
  assign m_o  = flags_q.m;
  assign t_o  = flags_q.t;

  // R2
  sign_setup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 2'b10) |=> (q_o == $past(rn_i[MSB])) && (m_o == $past(rm_i[MSB]))
                        && (t_o != (q_o == m_o)) && (rn_o == $past(rn_i)));

  // R3
  clear_setup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 2'b01) |=> !q_o && !m_o && !t_o && (rn_o == $past(rn_i)));

  // R4
  step_sub_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 2'b11 && q_i == m_i)
      |=> rn_o == ({$past(rn_i[MSB-1:0]), $past(t_i)} - $past(rm_i)));

  // R6
  step_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 2'b11) |=> (m_o == $past(m_i)) && (t_o == (q_o == m_o)));

  // R7
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 2'b00) |=> $stable(rn_o) && $stable(q_o) && $stable(m_o) && $stable(t_o));

endmodule

// File: tb/test_div_step_unit.sv
`timescale 1ns/1ps
module test_div_step_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  op = 2'b00;
  logic [31:0] rn = '0, rm = '0;
  logic        qi = 1'b0, mi = 1'b0, ti = 1'b0;
  logic [31:0] rn_o;
  logic        q_o, m_o, t_o;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;

  // reference state
  logic [31:0] e_rn = '0;
  logic        e_q = 0, e_m = 0, e_t = 0;

  always #10 clk = ~clk;

  div_step_unit i_div_step_unit (
    .clk_i(clk), .rst_ni(rst_n), .op_i(op), .rn_i(rn), .rm_i(rm),
    .q_i(qi), .m_i(mi), .t_i(ti),
    .rn_o(rn_o), .q_o(q_o), .m_o(m_o), .t_o(t_o)
  );

  task automatic compare(string req);
    n_vec++;
    if (rn_o !== e_rn || q_o !== e_q || m_o !== e_m || t_o !== e_t) begin
      n_bad++;
      $display("FAIL %s: got rn=%08h q=%b m=%b t=%b, expected rn=%08h q=%b m=%b t=%b",
               req, rn_o, q_o, m_o, t_o, e_rn, e_q, e_m, e_t);
    end
  endtask

  // behavioural model of one operation
  task automatic model(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b,
                       input logic q, input logic m, input logic t);
    longint unsigned sh, tot;
    bit c, nq;
    case (o)
      2'b01: begin e_rn = a; e_q = 0; e_m = 0; e_t = 0; end
      2'b10: begin e_rn = a; e_q = a[31]; e_m = b[31]; e_t = a[31] != b[31]; end
      2'b11: begin
        sh = ((longint'(a) << 1) | longint'(t)) & 64'hFFFF_FFFF;
        if (q == m) begin
          c   = longint'(b) > sh;
          tot = (sh - longint'(b)) & 64'hFFFF_FFFF;
        end else begin
          tot = sh + longint'(b);
          c   = tot > 64'hFFFF_FFFF;
          tot = tot & 64'hFFFF_FFFF;
        end
        nq = m ? !(a[31] ^ c) : (a[31] ^ c);
        e_rn = tot[31:0]; e_q = nq; e_m = m; e_t = (nq == m);
      end
      default: ;
    endcase
  endtask

  task automatic apply(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b,
                       input logic q, input logic m, input logic t, input string req);
    @(negedge clk);
    op = o; rn = a; rm = b; qi = q; mi = m; ti = t;
    model(o, a, b, q, m, t);
    @(negedge clk);
    compare(req);
  endtask

  task automatic udiv(input logic [31:0] a, input logic [31:0] b);
    logic [31:0] dvd;
    logic        tb_t, nt;
    dvd = a;
    apply(2'b01, 32'h0, b, 1'b1, 1'b1, 1'b1, "R9 setup");
    tb_t = t_o;
    for (int i = 0; i < 32; i++) begin
      nt  = dvd[31];
      dvd = {dvd[30:0], tb_t};
      apply(2'b11, rn_o, b, q_o, m_o, nt, "R9 step R5");
      tb_t = t_o;
    end
    dvd = {dvd[30:0], tb_t};
    n_vec++;
    if (dvd !== a / b) begin
      n_bad++;
      $display("FAIL R9: %08h/%08h got %08h expected %08h", a, b, dvd, a / b);
    end
  endtask

  function automatic void summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endfunction

  initial begin
    #(20ns * 200000);
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    summary();
  end

  initial begin
    logic [31:0] vals [6];
    vals = '{32'h0, 32'hFFFF_FFFF, 32'h8000_0000, 32'h7FFF_FFFF, 32'h1234_5678, 32'h0000_0001};

    // R1
    op = 2'b11; rn = 32'hDEAD_BEEF; rm = 32'h1; qi = 1; mi = 1; ti = 1;
    repeat (3) @(negedge clk);
    compare("R1 reset");
    rst_n = 1'b1;
    op = 2'b00;

    // R2 all sign combinations
    apply(2'b10, 32'h0000_0005, 32'h0000_0003, 0, 0, 0, "R2 ++");
    apply(2'b10, 32'h8000_0005, 32'h0000_0003, 0, 1, 1, "R2 -+");
    apply(2'b10, 32'h0000_0005, 32'hFFFF_FFFD, 1, 0, 0, "R2 +-");
    apply(2'b10, 32'hFFFF_FFFB, 32'hFFFF_FFFD, 0, 0, 1, "R2 -- R8");

    // R7 hold ignores all inputs
    apply(2'b00, 32'h1111_1111, 32'h8000_0000, 0, 1, 0, "R7 hold");
    apply(2'b00, 32'hFFFF_FFFF, 32'h0, 1, 0, 1, "R7 hold again");

    // R3 clears with all status inputs set
    apply(2'b01, 32'hCAFE_F00D, 32'h8000_0001, 1, 1, 1, "R3 clear");

    // R4 R5 R6 all status combinations over edge operands
    for (int f = 0; f < 8; f++)
      foreach (vals[i])
        for (int j = 0; j < 6; j++)
          apply(2'b11, vals[i], vals[j], f[2], f[1], f[0], "R4 R5 R6 step");

    for (int k = 0; k < 200; k++)
      apply(2'b11, $urandom, $urandom, 1'($urandom), 1'($urandom), 1'($urandom), "R5 random step");

    // R9 full unsigned divisions
    udiv(32'd100, 32'd7);
    udiv(32'd0, 32'd5);
    udiv(32'hFFFF_FFFF, 32'd1);
    udiv(32'hFFFF_FFFF, 32'hFFFF_FFFF);
    udiv(32'd5, 32'd9);
    udiv(32'h8000_0000, 32'd3);
    udiv(32'h1234_5678, 32'd1000);
    for (int k = 0; k < 20; k++) udiv($urandom, ($urandom >> (k % 31)) | 32'h1);

    summary();
  end

endmodule